// File: doc/BRIEF.md
# Card Host Interrupt Status and Classifier

This unit gathers the single-cycle event pulses of a card host controller into a sticky status register. It gates them with an enable register and drives one interrupt line. Software reads and writes both registers through a small register port, and clears status bits by writing ones to them.

At the start of each command the unit loads the enable register by itself. It also records which completion event will end the transaction. The choice depends on whether the command moves data, which way the data flows and whether hardware-flush mode is on. When that event arrives, the unit pulses a done flag. Together with the flag it presents a 2-bit command error code and a 2-bit data error code, each picked by fixed priority from the events seen so far.

Top module: `sdhost_irq_unit`

## Requirements
- R1: After reset the enable register and the status register read zero, `irq` is low, `xact_done` is low and both error codes are 0.
- R2: An event pulse on `evt[i]` sets status bit i from the next cycle on, and the bit stays set. Bit map: 0 response OK, 1 response CRC error, 2 response timeout, 3 RX FIFO full, 4 TX FIFO empty, 5 data CRC error, 6 data timeout, 7 data transfer OK, 8 DMA done.
- R3: A write with `reg_sel`=1 clears each status bit whose write-data bit is 1 and leaves the other bits unchanged. Writing 9'h1FF clears every bit. A write with `reg_sel`=0 loads the enable register. `reg_rdata` shows the status register when `reg_sel`=1 and the enable register when `reg_sel`=0.
- R4: When an event sets a status bit in the same cycle as a write that clears it, the bit stays set.
- R5: `irq` is high exactly when the bitwise AND of the enable register and the status register is nonzero.
- R6: The command error code takes its value by priority. Encodings: 0 none, 1 I/O, 2 CRC, 3 timeout. RX FIFO full or TX FIFO empty gives 1. Otherwise a response CRC error gives 2. Otherwise a response timeout gives 3. Otherwise the code is 0. The code looks at the status bits and at the events of the completing cycle.
- R7: For a data command, a data CRC error gives a data error code of 2. Otherwise a data timeout gives 3. Otherwise the code is 0. For a command without data, the data error code is 0.
- R8: A command without data completes on the response OK event.
- R9: A data command completes on DMA done when it is a write or when `hw_flush` is set. Otherwise it completes on data transfer OK. No other event completes it.
- R10: `cmd_start` loads the enable register with bits 1 to 6 plus the bit of the selected completion event. This load wins over a register write in the same cycle.
- R11: `xact_done` pulses for one cycle, in the cycle after the completion event, and the error codes are valid and held from that cycle on. Completion events that arrive after completion and before the next `cmd_start` produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt | input | 9 | Hardware event pulses (bit map in R2) |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the enable register, 1 selects the status register |
| reg_wdata | input | 9 | Register write data |
| reg_rdata | output | 9 | Read data of the selected register |
| cmd_start | input | 1 | Starts a command and captures its attributes |
| cmd_has_data | input | 1 | The command moves data |
| cmd_write | input | 1 | The data flows to the card |
| hw_flush | input | 1 | Hardware-flush mode |
| irq | output | 1 | Interrupt line |
| xact_done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 2 | Command error code |
| dat_err | output | 2 | Data error code |

## Verification
The assertions check on every cycle that events stick in the status register and that cleared bits drop. They also check that an empty status register keeps the interrupt low, that a command start opens the six error enables plus exactly one completion bit, and that the done flag never repeats without a new start. Only the bench's scenarios can show the error priorities and the choice of completion event across the data, direction and flush combinations. The same holds for the set-over-clear collision and for late completion events being ignored. For these, the bench compares the outputs against a behavioural model at every clock.

// File: rtl/sdhost_irq_unit.sv
module sdhost_irq_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [8:0] evt,
  input  logic       reg_wr,
  input  logic       reg_sel,
  input  logic [8:0] reg_wdata,
  output logic [8:0] reg_rdata,
  input  logic       cmd_start,
  input  logic       cmd_has_data,
  input  logic       cmd_write,
  input  logic       hw_flush,
  output logic       irq,
  output logic       xact_done,
  output logic [1:0] cmd_err,
  output logic [1:0] dat_err
);
  localparam int NEV = 9;
  localparam logic [3:0] B_RSP_OK = 4'd0;
  localparam int B_RSP_CRC = 1;
  localparam int B_RSP_TMO = 2;
  localparam int B_RXF_FULL = 3;
  localparam int B_TXF_EMPTY = 4;
  localparam int B_DAT_CRC = 5;
  localparam int B_DAT_TMO = 6;
  localparam logic [3:0] B_XFER_OK = 4'd7;
  localparam logic [3:0] B_DMA_DONE = 4'd8;
  localparam logic [NEV-1:0] ERR_MASK = 9'h07E;

  logic [NEV-1:0] en_q, sta_q;
  logic           active_q, ctx_data_q;
  logic [3:0]     comp_q, comp_d;
  logic [1:0]     cerr_d, derr_d;

  wire [NEV-1:0] clr  = (reg_wr && reg_sel) ? reg_wdata : '0;
  wire [NEV-1:0] seen = sta_q | evt;
  wire           fin  = active_q && evt[comp_q];

  assign comp_d = !cmd_has_data ? B_RSP_OK :
                  (cmd_write || hw_flush) ? B_DMA_DONE : B_XFER_OK;

  always_comb begin
    if (seen[B_RXF_FULL] || seen[B_TXF_EMPTY]) cerr_d = 2'd1;
    else if (seen[B_RSP_CRC])                  cerr_d = 2'd2;
    else if (seen[B_RSP_TMO])                  cerr_d = 2'd3;
    else                                       cerr_d = 2'd0;
    if (!ctx_data_q)                           derr_d = 2'd0;
    else if (seen[B_DAT_CRC])                  derr_d = 2'd2;
    else if (seen[B_DAT_TMO])                  derr_d = 2'd3;
    else                                       derr_d = 2'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q       <= '0;
      sta_q      <= '0;
      active_q   <= 1'b0;
      ctx_data_q <= 1'b0;
      comp_q     <= B_RSP_OK;
      xact_done  <= 1'b0;
      cmd_err    <= 2'd0;
      dat_err    <= 2'd0;
    end else begin
      sta_q     <= (sta_q & ~clr) | evt;
      xact_done <= fin;
      if (fin) begin
        cmd_err <= cerr_d;
        dat_err <= derr_d;
      end
      if (cmd_start) begin
        en_q       <= ERR_MASK | (9'd1 << comp_d);
        active_q   <= 1'b1;
        ctx_data_q <= cmd_has_data;
        comp_q     <= comp_d;
      end else begin
        if (reg_wr && !reg_sel) en_q <= reg_wdata;
        if (fin) active_q <= 1'b0;
      end
    end
  end

  assign irq       = |(en_q & sta_q);
  assign reg_rdata = reg_sel ? sta_q : en_q;
endmodule

// File: rtl/sdhost_irq_unit_chk.sv
module sdhost_irq_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [8:0] evt,
  input logic       reg_wr,
  input logic       reg_sel,
  input logic [8:0] reg_wdata,
  input logic [8:0] en_q,
  input logic [8:0] sta_q,
  input logic       cmd_start,
  input logic       irq,
  input logic       xact_done
);
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((sta_q & $past(evt)) == $past(evt)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel && evt == 9'd0) |=> ((sta_q & $past(reg_wdata)) == 9'd0));

  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sta_q == 9'd0) |-> !irq);

  p_start_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> ((en_q & 9'h07E) == 9'h07E) && ($countones(en_q) == 7));

  p_one_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (xact_done && !$past(cmd_start)) |=> !xact_done);
endmodule

bind sdhost_irq_unit sdhost_irq_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .evt(evt), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .en_q(en_q), .sta_q(sta_q), .cmd_start(cmd_start),
  .irq(irq), .xact_done(xact_done)
);

// File: tb/sdhost_irq_unit_tb_top.sv
module sdhost_irq_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [8:0] evt = '0;
  logic reg_wr = 1'b0, reg_sel = 1'b0;
  logic [8:0] reg_wdata = '0;
  logic [8:0] reg_rdata;
  logic cmd_start = 1'b0, cmd_has_data = 1'b0, cmd_write = 1'b0, hw_flush = 1'b0;
  logic irq, xact_done;
  logic [1:0] cmd_err, dat_err;

  always #4 clk = ~clk;

  sdhost_irq_unit dut_i (.*);

  int total = 0, bad = 0;
  bit finished = 0;

  int m_en = 0, m_sta = 0, m_done = 0, m_cerr = 0, m_derr = 0;
  int m_active = 0, m_data = 0, m_comp = 0;

  function automatic int pick_comp(bit d, bit w, bit f);
    if (!d) return 0;
    if (w || f) return 8;
    return 7;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_sta = 0; m_done = 0; m_cerr = 0; m_derr = 0;
      m_active = 0; m_data = 0; m_comp = 0;
    end else begin
      int e, s, fin;
      e = int'(evt);
      s = m_sta | e;
      fin = (m_active != 0) && e[m_comp];
      m_done = fin;
      if (fin) begin
        if (s[3] || s[4]) m_cerr = 1;
        else if (s[1]) m_cerr = 2;
        else if (s[2]) m_cerr = 3;
        else m_cerr = 0;
        if (!m_data) m_derr = 0;
        else if (s[5]) m_derr = 2;
        else if (s[6]) m_derr = 3;
        else m_derr = 0;
      end
      if (reg_wr && reg_sel) m_sta = (m_sta & ~int'(reg_wdata)) | e;
      else m_sta = m_sta | e;
      if (cmd_start) begin
        m_comp = pick_comp(cmd_has_data, cmd_write, hw_flush);
        m_en = 32'h7E | (1 << m_comp);
        m_active = 1;
        m_data = cmd_has_data;
      end else begin
        if (reg_wr && !reg_sel) m_en = int'(reg_wdata);
        if (fin) m_active = 0;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R5 irq", int'(irq), ((m_en & m_sta) != 0) ? 1 : 0);
    chk("R8 R9 R11 xact_done", int'(xact_done), m_done);
    chk("R6 cmd_err", int'(cmd_err), m_cerr);
    chk("R7 dat_err", int'(dat_err), m_derr);
    if (reg_sel) chk("R2 R3 R4 status", int'(reg_rdata), m_sta);
    else chk("R10 R3 enable", int'(reg_rdata), m_en);
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic idle();
    evt = '0; reg_wr = 0; cmd_start = 0;
  endtask

  task automatic start(bit d, bit w, bit f);
    cmd_start = 1; cmd_has_data = d; cmd_write = w; hw_flush = f;
    step(); cmd_start = 0;
  endtask

  task automatic pulse(logic [8:0] v);
    evt = v; step(); evt = '0;
  endtask

  task automatic wr(bit sel, logic [8:0] d);
    reg_wr = 1; reg_sel = sel; reg_wdata = d; step(); reg_wr = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    step(3);
    rst_n = 1;
    step();
    // R1 reset state
    reg_sel = 0; #1;
    chk("R1 enable", int'(reg_rdata), 0);
    reg_sel = 1; #1;
    chk("R1 status", int'(reg_rdata), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 done", int'(xact_done), 0);
    chk("R1 errors", int'({cmd_err, dat_err}), 0);

    // R2 sticky set, R3 partial clear and all-ones clear
    pulse(9'h021); step(2);
    wr(1, 9'h001); step();
    pulse(9'h1C0); wr(1, 9'h1FF); step();
    // R4 set and clear in the same cycle
    evt = 9'h004; reg_wr = 1; reg_sel = 1; reg_wdata = 9'h1FF; step(); idle(); step();
    wr(1, 9'h1FF);
    // R5 enable masking via the register port
    wr(0, 9'h010); pulse(9'h008); step(); pulse(9'h010); step(); wr(1, 9'h1FF);

    // R8 command without data: late xfer/dma events do not finish it
    start(0, 0, 0); pulse(9'h180); step(); pulse(9'h001); step(2); pulse(9'h001); step(); wr(1, 9'h1FF);
    // R6 priority: CRC beats timeout, FIFO beats CRC
    start(0, 0, 0); pulse(9'h006); pulse(9'h001); step(); wr(1, 9'h1FF);
    start(0, 0, 0); pulse(9'h012); pulse(9'h001); step(); wr(1, 9'h1FF);
    start(0, 0, 0); pulse(9'h005); step(); wr(1, 9'h1FF);
    // R9 data read, no flush: xfer ok; R7 data CRC beats timeout
    start(1, 0, 0); pulse(9'h100); pulse(9'h060); pulse(9'h080); step(); wr(1, 9'h1FF);
    // R9 data write: dma done; R7 timeout only
    start(1, 1, 0); pulse(9'h080); pulse(9'h040); pulse(9'h100); step(); wr(1, 9'h1FF);
    // R9 read with hw flush: dma done
    start(1, 0, 1); pulse(9'h080); pulse(9'h108); step(); wr(1, 9'h1FF);
    // R10 start wins over enable write in same cycle
    reg_wr = 1; reg_sel = 0; reg_wdata = 9'h000; start(1, 0, 0); reg_wr = 0; reg_sel = 1; step();
    reg_sel = 0; step(); reg_sel = 1; pulse(9'h080); step(); wr(1, 9'h1FF);

    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      evt = (r < 40) ? 9'(1 << $urandom_range(0, 8)) : 9'h000;
      reg_wr = ($urandom_range(0, 9) == 0);
      reg_sel = $urandom_range(0, 1);
      reg_wdata = 9'($urandom_range(0, 511));
      cmd_start = ($urandom_range(0, 19) == 0);
      cmd_has_data = $urandom_range(0, 1);
      cmd_write = $urandom_range(0, 1);
      hw_flush = $urandom_range(0, 1);
      step();
    end
    idle(); step(2);
    summary();
  end
endmodule